// File: doc/BRIEF.md
# Shared Interrupt Source Router

The router collects a group of level-sensitive external interrupt lines and steers each one to a single output pin of a single core. Every line holds four pieces of state: a pending level, an enable bit, a target pin number and a target core. A core output pin is high whenever at least one line is enabled, pending and mapped to that core and pin. Software uses a word-wide register bus with byte addressing to turn enables on and off in bulk, to read pending and enable bitmaps, to program the mappings, and to force a line's pending level high or low.

The pending level of a line follows its hardware input and is updated whenever that input changes. A software trigger register can also drive the pending level in either direction. The pending level is held while the line is disabled, so enabling the line later raises its output at once. The line count (a nonzero multiple of 8, at most 256), the core count and the number of pins per core are parameters. The bus side is a two-state machine. `ST_IDLE` moves to `ST_RESP` on a read request. `ST_RESP` stays in `ST_RESP` on a back-to-back read and returns to `ST_IDLE` otherwise. Read data is presented in `ST_RESP`, and writes complete without a state change.

Top module: `srr_router`

## Requirements
- R1: After reset every line is disabled and not pending, its pin map reads 0x8000_0000 (pin 0, route flag set), its core map reads 0, `core_irq` is all zero and `bus_rvalid` is low.
- R2: The word at 0x000 is read-only and returns NUM_LINES/8−1 in bits [7:0] and NUM_CORES in bits [23:16], with all other bits zero.
- R3: A write to the set-enable word at 0x060+4w enables line 32w+b for every 1 in bit b. A write to the clear-enable word at 0x080+4w disables those lines. Zero bits leave enables unchanged.
- R4: The pending bitmap at 0x020+4w and the enable bitmap at 0x040+4w return the state of line 32w+b in bit b. Bits for lines at or above NUM_LINES read 0.
- R5: A write to the trigger word at 0x0A0 names a line in bits [7:0]. A 1 in bit 31 sets that line's pending level and a 0 clears it. A line number at or above NUM_LINES changes nothing.
- R6: A change on `irq_in[i]` copies the new level into line i's pending level on the next clock edge, whether or not the line is enabled. A trigger write to the same line in the same cycle takes priority.
- R7: The pin map of line n is the word at 0x400+4n. Bits [5:0] hold the pin and bit 31 holds the route flag, and the word reads back as {flag, 25'b0, pin}. A write whose pin field exceeds NUM_PINS−1 is dropped.
- R8: The core map of line n is the first word of a 32-byte stride at 0x2000+32n. A nonzero write stores the index of its lowest set bit, and a zero write leaves the line unmapped. A write whose lowest set bit is at or above NUM_CORES is dropped. A read returns 1 shifted left by the stored index, or 0 when the line is unmapped. The other words of the stride read 0.
- R9: `core_irq[c*NUM_PINS+p]` is the OR over all lines that are enabled, pending and mapped to core c and pin p. An unmapped line drives no output. The output reflects any enable, pending or map change from the clock edge that records it.
- R10: A read request in one cycle produces `bus_rvalid` and its data in the next cycle. `bus_rvalid` is low in any cycle that does not follow a read request.
- R11: An access to a line index at or above NUM_LINES, or to an unassigned address, writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | External interrupt levels |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| core_irq | output | NUM_CORES*NUM_PINS | Interrupt pins, bit c*NUM_PINS+p |

## Verification
Several properties are checked on every cycle. The read handshake timing is checked throughout. So is the rule that a raised core pin always has an enabled, pending line behind it. Set-enable, clear-enable and trigger writes are checked against line 0's stored state, and a core-map write above the core count must leave the map unchanged. The bench scenarios are needed for the rest: exact bitmap bit positions, pin and core readback encodings, the drop rules on out-of-range values, the priority of a trigger over a simultaneous input edge, and the OR of several lines onto one pin.

// File: rtl/srr_pkg.sv
package srr_pkg;
    localparam int ADDR_W      = 14;
    localparam int PIN_FIELD_W = 6;

    typedef enum logic [3:0] {
        RG_NONE, RG_CONFIG, RG_PEND, RG_ENAB, RG_SETEN,
        RG_CLREN, RG_TRIG, RG_PINMAP, RG_COREMAP
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [2:0] word;
        logic [7:0] line;
    } dec_t;

    typedef enum logic {ST_IDLE, ST_RESP} bus_st_e;
endpackage

// File: rtl/srr_decode.sv
module srr_decode import srr_pkg::*; (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [1:0] unused_lsb;
    assign unused_lsb = addr[1:0];

    always_comb begin
        dec.region = RG_NONE;
        dec.word   = addr[4:2];
        dec.line   = 8'd0;
        if (addr[13]) begin
            dec.line = addr[12:5];
            if (addr[4:2] == 3'd0) dec.region = RG_COREMAP;
        end else if (addr[13:10] == 4'b0001) begin
            dec.line   = addr[9:2];
            dec.region = RG_PINMAP;
        end else if (addr[13:8] == 6'd0) begin
            unique case (addr[7:5])
                3'd0: if (addr[4:2] == 3'd0) dec.region = RG_CONFIG;
                3'd1: dec.region = RG_PEND;
                3'd2: dec.region = RG_ENAB;
                3'd3: dec.region = RG_SETEN;
                3'd4: dec.region = RG_CLREN;
                3'd5: if (addr[4:2] == 3'd0) dec.region = RG_TRIG;
                default: dec.region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/srr_line_bank.sv
module srr_line_bank import srr_pkg::*; #(
    parameter int NUM_LINES = 32,
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 6,
    parameter int CORE_W    = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_LINES-1:0]                   irq_in,
    input  logic                                   wr,
    input  dec_t                                   dec,
    input  logic [31:0]                            wdata,
    output logic [NUM_LINES-1:0]                   en_q,
    output logic [NUM_LINES-1:0]                   pend_q,
    output logic [NUM_LINES-1:0]                   flag_q,
    output logic [NUM_LINES-1:0][PIN_FIELD_W-1:0]  pin_q,
    output logic [NUM_LINES-1:0]                   core_vld_q,
    output logic [NUM_LINES-1:0][CORE_W-1:0]       core_idx_q
);
    logic [NUM_LINES-1:0] in_prev_q;
    int                   low_idx;
    logic                 core_ok;
    logic                 pin_ok;

    always_comb begin
        low_idx = 0;
        for (int b = 31; b >= 0; b--) begin
            if (wdata[b]) low_idx = b;
        end
        core_ok = (wdata == 32'd0) || (low_idx < NUM_CORES);
        pin_ok  = wdata[PIN_FIELD_W-1:0] <= PIN_FIELD_W'(NUM_PINS - 1);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam logic [2:0] WSEL = 3'(i / 32);
        localparam int         BSEL = i % 32;
        logic line_hit, set_hit, clr_hit, trig_hit;

        assign line_hit = dec.line == 8'(i);
        assign set_hit  = wr && dec.region == RG_SETEN && dec.word == WSEL && wdata[BSEL];
        assign clr_hit  = wr && dec.region == RG_CLREN && dec.word == WSEL && wdata[BSEL];
        assign trig_hit = wr && dec.region == RG_TRIG && wdata[7:0] == 8'(i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[i]       <= 1'b0;
                pend_q[i]     <= 1'b0;
                in_prev_q[i]  <= 1'b0;
                flag_q[i]     <= 1'b1;
                pin_q[i]      <= '0;
                core_vld_q[i] <= 1'b0;
                core_idx_q[i] <= '0;
            end else begin
                in_prev_q[i] <= irq_in[i];
                if (set_hit)      en_q[i] <= 1'b1;
                else if (clr_hit) en_q[i] <= 1'b0;
                if (trig_hit)                        pend_q[i] <= wdata[31];
                else if (irq_in[i] != in_prev_q[i])  pend_q[i] <= irq_in[i];
                if (wr && dec.region == RG_PINMAP && line_hit && pin_ok) begin
                    flag_q[i] <= wdata[31];
                    pin_q[i]  <= wdata[PIN_FIELD_W-1:0];
                end
                if (wr && dec.region == RG_COREMAP && line_hit && core_ok) begin
                    core_vld_q[i] <= wdata != 32'd0;
                    core_idx_q[i] <= CORE_W'(low_idx);
                end
            end
        end
    end
endmodule

// File: rtl/srr_pin_merge.sv
module srr_pin_merge import srr_pkg::*; #(
    parameter int NUM_LINES = 32,
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 6,
    parameter int CORE_W    = 2
) (
    input  logic [NUM_LINES-1:0]                  en_q,
    input  logic [NUM_LINES-1:0]                  pend_q,
    input  logic [NUM_LINES-1:0][PIN_FIELD_W-1:0] pin_q,
    input  logic [NUM_LINES-1:0]                  core_vld_q,
    input  logic [NUM_LINES-1:0][CORE_W-1:0]      core_idx_q,
    output logic [NUM_CORES*NUM_PINS-1:0]         core_irq
);
    logic [NUM_LINES-1:0] live;
    assign live = en_q & pend_q & core_vld_q;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [NUM_LINES-1:0] hit;
            for (genvar l = 0; l < NUM_LINES; l++) begin : g_src
                assign hit[l] = live[l] && core_idx_q[l] == CORE_W'(c)
                                && pin_q[l] == PIN_FIELD_W'(p);
            end
            assign core_irq[c*NUM_PINS+p] = |hit;
        end
    end
endmodule

// File: rtl/srr_router.sv
module srr_router import srr_pkg::*; #(
    parameter int NUM_LINES = 32,
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-1:0]          irq_in,
    input  logic                          bus_req,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          bus_rvalid,
    output logic [NUM_CORES*NUM_PINS-1:0] core_irq
);
    localparam int         CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam logic [7:0] CFG_LINES = 8'(NUM_LINES / 8 - 1);
    localparam logic [7:0] CFG_CORES = 8'(NUM_CORES);

    dec_t                                  dec;
    logic                                  wr, rd;
    logic [NUM_LINES-1:0]                  en_q, pend_q, flag_q, core_vld_q;
    logic [NUM_LINES-1:0][PIN_FIELD_W-1:0] pin_q;
    logic [NUM_LINES-1:0][CORE_W-1:0]      core_idx_q;
    logic [31:0]                           rd_word;
    bus_st_e                               st_q, st_d;

    assign wr = bus_req && bus_we;
    assign rd = bus_req && !bus_we;

    srr_decode u_dec (.addr(bus_addr), .dec(dec));

    srr_line_bank #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES),
                    .NUM_PINS(NUM_PINS), .CORE_W(CORE_W)) u_bank (
        .clk, .rst_n, .irq_in, .wr, .dec, .wdata(bus_wdata),
        .en_q, .pend_q, .flag_q, .pin_q, .core_vld_q, .core_idx_q
    );

    srr_pin_merge #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES),
                    .NUM_PINS(NUM_PINS), .CORE_W(CORE_W)) u_merge (
        .en_q, .pend_q, .pin_q, .core_vld_q, .core_idx_q, .core_irq
    );

    always_comb begin
        rd_word = 32'd0;
        unique case (dec.region)
            RG_CONFIG: rd_word = {8'd0, CFG_CORES, 8'd0, CFG_LINES};
            RG_PEND, RG_ENAB: begin
                for (int l = 0; l < NUM_LINES; l++) begin
                    if (3'(l / 32) == dec.word)
                        rd_word[l % 32] = (dec.region == RG_PEND) ? pend_q[l] : en_q[l];
                end
            end
            RG_PINMAP: begin
                for (int l = 0; l < NUM_LINES; l++) begin
                    if (dec.line == 8'(l)) rd_word = {flag_q[l], 25'd0, pin_q[l]};
                end
            end
            RG_COREMAP: begin
                for (int l = 0; l < NUM_LINES; l++) begin
                    if (dec.line == 8'(l) && core_vld_q[l])
                        rd_word = 32'd1 << core_idx_q[l];
                end
            end
            default: rd_word = 32'd0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (rd) st_d = ST_RESP;
            ST_RESP: st_d = rd ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bus_rdata <= 32'd0;
        else if (rd) bus_rdata <= rd_word;
    end

    assign bus_rvalid = (st_q == ST_RESP);
endmodule

// File: rtl/srr_router_chk.sv
module srr_router_chk #(
    parameter int NUM_LINES = 32,
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 6,
    parameter int CORE_W    = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_req,
    input logic                             bus_we,
    input logic [13:0]                      bus_addr,
    input logic [31:0]                      bus_wdata,
    input logic                             bus_rvalid,
    input logic [NUM_CORES*NUM_PINS-1:0]    core_irq,
    input logic [NUM_LINES-1:0]             en_q,
    input logic [NUM_LINES-1:0]             pend_q,
    input logic [NUM_LINES-1:0]             core_vld_q,
    input logic [NUM_LINES-1:0][CORE_W-1:0] core_idx_q
);
    initial begin
        AST_CFG_VALID: assert (NUM_LINES > 0 && NUM_LINES % 8 == 0 && NUM_LINES <= 256
                               && NUM_CORES >= 1 && NUM_CORES <= 32 && NUM_PINS <= 64)
            else $error("bad router configuration"); // R2
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |=> bus_rvalid); // R10
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid); // R10
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_irq) |-> (|(en_q & pend_q & core_vld_q))); // R9
    AST_SET_EN_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 14'h060 && bus_wdata[0] |=> en_q[0]); // R3
    AST_CLR_EN_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 14'h080 && bus_wdata[0] |=> !en_q[0]); // R3
    AST_TRIG_SET_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 14'h0A0 && bus_wdata == 32'h8000_0000 |=> pend_q[0]); // R5
    AST_CORE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 14'h2000 && NUM_CORES < 32
        && bus_wdata == (32'd1 << NUM_CORES)
        |=> $stable(core_vld_q[0]) && $stable(core_idx_q[0])); // R8
endmodule

bind srr_router srr_router_chk #(
    .NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES),
    .NUM_PINS(NUM_PINS), .CORE_W(CORE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .core_irq(core_irq), .en_q(en_q), .pend_q(pend_q),
    .core_vld_q(core_vld_q), .core_idx_q(core_idx_q)
);

// File: tb/srr_router_bench.sv
`timescale 1ns/1ps
module srr_router_bench;
    localparam int NL = 32;
    localparam int NC = 4;
    localparam int NP = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL-1:0]     irq_in = '0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [13:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NC*NP-1:0]  core_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    srr_router #(.NUM_LINES(NL), .NUM_CORES(NC), .NUM_PINS(NP)) u_srr_router (
        .clk, .rst_n, .irq_in, .bus_req, .bus_we, .bus_addr, .bus_wdata,
        .bus_rdata, .bus_rvalid, .core_irq
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        checks++;
        if (bus_rvalid !== 1'b1) begin
            failures++;
            $display("FAIL R10 rvalid actual=%b expected=1", bus_rvalid);
        end
        d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [13:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset;
        check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        check("R1 core_irq", 32'(core_irq), 32'd0);
        rd_chk("R1 pend", 14'h020, 32'd0);
        rd_chk("R1 enable", 14'h040, 32'd0);
        rd_chk("R1 pinmap", 14'h40C, 32'h8000_0000);
        rd_chk("R1 coremap", 14'h2060, 32'd0);
        rd_chk("R2 config", 14'h000, 32'h0004_0003);
        @(negedge clk);
        check("R10 idle rvalid", {31'd0, bus_rvalid}, 32'd0);
    endtask

    task automatic t_enables;
        wr(14'h060, 32'h0000_00A5);
        rd_chk("R3 set", 14'h040, 32'h0000_00A5);
        wr(14'h080, 32'h0000_0005);
        rd_chk("R3 clear", 14'h040, 32'h0000_00A0);
        wr(14'h060, 32'h0000_0000);
        rd_chk("R3 zero write", 14'h040, 32'h0000_00A0);
        rd_chk("R4 enable beyond lines", 14'h044, 32'd0);
        wr(14'h080, 32'hFFFF_FFFF);
        rd_chk("R3 clear all", 14'h040, 32'd0);
    endtask

    task automatic t_trigger;
        wr(14'h0A0, 32'h8000_0005);
        rd_chk("R5 R6 pend while disabled", 14'h020, 32'h0000_0020);
        wr(14'h0A0, 32'h0000_0005);
        rd_chk("R5 deassert", 14'h020, 32'd0);
        wr(14'h0A0, 32'h8000_0028);
        rd_chk("R5 R11 out of range trig", 14'h020, 32'd0);
        rd_chk("R4 pend beyond lines", 14'h024, 32'd0);
        rd_chk("R11 unassigned addr", 14'h300, 32'd0);
    endtask

    task automatic t_hwin;
        irq_in[9] = 1'b1;
        @(negedge clk);
        rd_chk("R6 input rise", 14'h020, 32'h0000_0200);
        irq_in[9] = 1'b0;
        @(negedge clk);
        rd_chk("R6 input fall", 14'h020, 32'd0);
        irq_in[10] = 1'b1;
        wr(14'h0A0, 32'h0000_000A);
        rd_chk("R6 trigger priority", 14'h020, 32'd0);
        irq_in[10] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_pinmap;
        wr(14'h40C, 32'h0000_0004);
        rd_chk("R7 pin write", 14'h40C, 32'h0000_0004);
        wr(14'h40C, 32'h8000_0007);
        rd_chk("R7 pin reject", 14'h40C, 32'h0000_0004);
        wr(14'h40C, 32'hFFFF_FF05);
        rd_chk("R7 flag and pin", 14'h40C, 32'h8000_0005);
        wr(14'h4A0, 32'h0000_0001);
        rd_chk("R11 pinmap out of range", 14'h4A0, 32'd0);
    endtask

    task automatic t_coremap;
        wr(14'h2060, 32'h0000_0004);
        rd_chk("R8 core write", 14'h2060, 32'h0000_0004);
        wr(14'h2060, 32'h0000_0030);
        rd_chk("R8 core reject", 14'h2060, 32'h0000_0004);
        wr(14'h2060, 32'h0000_000A);
        rd_chk("R8 lowest bit", 14'h2060, 32'h0000_0002);
        rd_chk("R8 stride word", 14'h2064, 32'd0);
        wr(14'h2060, 32'd0);
        rd_chk("R8 unmap", 14'h2060, 32'd0);
        wr(14'h2500, 32'h0000_0001);
        rd_chk("R11 coremap out of range", 14'h2500, 32'd0);
    endtask

    task automatic t_routing;
        wr(14'h40C, 32'h8000_0002);   // line 3 -> pin 2
        wr(14'h2060, 32'h0000_0002);  // line 3 -> core 1
        wr(14'h0A0, 32'h8000_0003);
        check("R9 disabled no irq", 32'(core_irq), 32'd0);
        wr(14'h060, 32'h0000_0008);
        check("R9 enabled irq", 32'(core_irq), 32'h100);
        wr(14'h080, 32'h0000_0008);
        check("R9 disable recompute", 32'(core_irq), 32'd0);
        wr(14'h060, 32'h0000_0058);   // lines 3,4,6
        wr(14'h410, 32'h0000_0002);   // line 4 -> pin 2
        wr(14'h2080, 32'h0000_0002);  // line 4 -> core 1
        wr(14'h0A0, 32'h8000_0004);
        wr(14'h0A0, 32'h0000_0003);
        check("R9 OR of lines", 32'(core_irq), 32'h100);
        wr(14'h0A0, 32'h8000_0006);   // line 6 unmapped
        wr(14'h0A0, 32'h0000_0004);
        check("R9 unmapped silent", 32'(core_irq), 32'd0);
        wr(14'h2080, 32'h0000_0001);  // line 4 -> core 0
        wr(14'h0A0, 32'h8000_0004);
        check("R9 core 0 pin 2", 32'(core_irq), 32'h004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enables;
        t_trigger;
        t_hwin;
        t_pinmap;
        t_coremap;
        t_routing;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule